// File: doc/BRIEF.md
# Trapezoidal Peak-Time Trigger

This block is a low-noise event trigger for a stream of signed 14-bit ADC samples. Two moving-sum windows are chained to shape the input into a trapezoid. Each window keeps a running total that adds each new sample and removes the sample that leaves the window, which needs a delay line. Convolving two rectangles gives a trapezoid. Its overall length and flat top are chosen at build time, and from them the two window lengths are derived with rounding.

An event is reported only when the shaped signal goes strictly above a programmable threshold. The event is timed at the top of the shaped pulse, not at the threshold crossing, because the crossing moves with pulse amplitude. When the trigger fires it emits a one-cycle pulse and presents the peak value. It then waits until the shaped signal has fallen back to or below the threshold before it can fire again.

Top module: `trap_peak_trigger`

## Requirements
- R1: While reset (rst_ni low) is applied and afterwards until the first event, event_o is 0 and peak_o is 0.
- R2: The shaped value is the sum of LEN_B consecutive outputs of an LEN_A-sample moving sum of the input. LEN_A = (TRAP_LEN+TRAP_FLAT+1)/2 and LEN_B = (TRAP_LEN-TRAP_FLAT+1)/2. The defaults (12, 4) give 8 and 4. The value is exact for full-scale inputs of either sign: accumulator wrap-around cancels.
- R3: An event occurs only if the shaped maximum is strictly greater than thresh_i (signed compare). A maximum equal to the threshold does not fire.
- R4: The peak sample is the first valid shaped sample that the next one does not exceed. With valid_i high every cycle, take sample index p as the input sample whose shaped value is the peak, and number clock edges from 0 at the edge that captures input sample 0. Then event_o is high in the cycle after edge p+3, whatever the amplitude.
- R5: With each event, peak_o presents the peak shaped value. It holds that value until the next event and changes at no other time.
- R6: After an event no further event occurs until a shaped sample is at or below thresh_i. After that the trigger is armed again.
- R7: event_o is high for exactly one clock cycle per event.
- R8: Cycles with valid_i low advance no state. The value on sample_i during such cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Qualifies sample_i |
| sample_i | input | DATA_W | Two's complement ADC sample |
| thresh_i | input | SUM_W | Signed detection threshold on the shaped value |
| event_o | output | 1 | One-cycle event pulse |
| peak_o | output | SUM_W | Peak shaped value of the last event |

## Verification
The bench drives rectangular pulses of several widths and signs. It checks the event edge and the peak value against a trapezoid worked out from the window lengths. A design that timed events at the crossing, or that took the last plateau sample instead of the first, would report the event at a different edge for the wide pulses. Thresholds set exactly at the peak and one below it expose an off-by-one compare. Full-scale positive and negative bursts expose an accumulator that is too narrow, as a wrong or spurious peak. Two overlapping pulses must give one event and two separated pulses must give two; a design that re-armed too early or never re-armed would get those counts wrong. A burst with gaps in valid_i, carrying junk data during the gaps, shows whether stalled cycles leak into the filter.

// File: rtl/trap_trig_pkg.sv
package trap_trig_pkg;

    // Longer rectangle: sets the rise plus flat part of the trapezoid.
    function automatic int rect_long(input int total_len, input int flat_len);
        return (total_len + flat_len + 1) / 2;
    endfunction

    // Shorter rectangle: sets the ramp length of the trapezoid.
    function automatic int rect_short(input int total_len, input int flat_len);
        return (total_len - flat_len + 1) / 2;
    endfunction

endpackage

// File: rtl/trap_boxcar.sv
module trap_boxcar #(
    parameter int IN_W  = 14,
    parameter int OUT_W = 20,
    parameter int LEN   = 8
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    vld_i,
    input  logic signed [IN_W-1:0]  din_i,
    output logic                    vld_o,
    output logic signed [OUT_W-1:0] dout_o
);

    typedef struct packed {
        logic                    vld;
        logic signed [OUT_W-1:0] acc;
    } box_state_t;

    box_state_t st_d, st_q;
    logic signed [IN_W-1:0] tap_q [LEN];

    // Delay line: the sample leaving the window appears at the last tap.
    for (genvar i = 0; i < LEN; i++) begin : g_tap
        if (i == 0) begin : g_head
            always_ff @(posedge clk_i) begin
                if (!rst_ni)    tap_q[i] <= '0;
                else if (vld_i) tap_q[i] <= din_i;
            end
        end else begin : g_body
            always_ff @(posedge clk_i) begin
                if (!rst_ni)    tap_q[i] <= '0;
                else if (vld_i) tap_q[i] <= tap_q[i-1];
            end
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i) begin
            // Modular arithmetic: wrap in the running total cancels.
            st_d.acc = st_q.acc + OUT_W'(din_i) - OUT_W'(tap_q[LEN-1]);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign vld_o  = st_q.vld;
    assign dout_o = st_q.acc;

endmodule

// File: rtl/trap_peak_detect.sv
module trap_peak_detect #(
    parameter int W = 26
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                vld_i,
    input  logic signed [W-1:0] data_i,
    input  logic signed [W-1:0] thresh_i,
    output logic                event_o,
    output logic signed [W-1:0] peak_o
);

    typedef struct packed {
        logic                armed;
        logic                have_prev;
        logic signed [W-1:0] prev;
        logic                evt;
        logic signed [W-1:0] peak;
    } pk_state_t;

    pk_state_t st_d, st_q;
    logic      above;
    logic      fire;

    always_comb begin
        st_d     = st_q;
        st_d.evt = 1'b0;
        above    = st_q.have_prev && (st_q.prev > thresh_i);
        fire     = vld_i && st_q.armed && above && (data_i <= st_q.prev);
        if (vld_i) begin
            if (fire) begin
                st_d.evt  = 1'b1;
                st_d.peak = st_q.prev;
            end
            // Falling to or below threshold re-arms; firing disarms.
            if (data_i <= thresh_i) st_d.armed = 1'b1;
            else if (fire)          st_d.armed = 1'b0;
            st_d.prev      = data_i;
            st_d.have_prev = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q       <= '0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign event_o = st_q.evt;
    assign peak_o  = st_q.peak;

endmodule

// File: rtl/trap_peak_trigger.sv
module trap_peak_trigger #(
    parameter int DATA_W    = 14,
    parameter int TRAP_LEN  = 12,
    parameter int TRAP_FLAT = 4,
    parameter int MAX_DEPTH = 64,
    localparam int GROW  = $clog2(MAX_DEPTH),
    localparam int SUM_W = DATA_W + 2 * GROW
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    valid_i,
    input  logic signed [DATA_W-1:0] sample_i,
    input  logic signed [SUM_W-1:0] thresh_i,
    output logic                    event_o,
    output logic signed [SUM_W-1:0] peak_o
);

    localparam int LEN_A = trap_trig_pkg::rect_long(TRAP_LEN, TRAP_FLAT);
    localparam int LEN_B = trap_trig_pkg::rect_short(TRAP_LEN, TRAP_FLAT);
    localparam int MID_W = DATA_W + GROW;

    logic                    mid_vld;
    logic signed [MID_W-1:0] mid_data;
    logic                    filt_vld;
    logic signed [SUM_W-1:0] filt_data;

    trap_boxcar #(.IN_W(DATA_W), .OUT_W(MID_W), .LEN(LEN_A)) u_box_long (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .vld_i  (valid_i),
        .din_i  (sample_i),
        .vld_o  (mid_vld),
        .dout_o (mid_data)
    );

    trap_boxcar #(.IN_W(MID_W), .OUT_W(SUM_W), .LEN(LEN_B)) u_box_short (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .vld_i  (mid_vld),
        .din_i  (mid_data),
        .vld_o  (filt_vld),
        .dout_o (filt_data)
    );

    trap_peak_detect #(.W(SUM_W)) u_peak (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .vld_i    (filt_vld),
        .data_i   (filt_data),
        .thresh_i (thresh_i),
        .event_o  (event_o),
        .peak_o   (peak_o)
    );

endmodule

// File: rtl/trap_peak_trigger_chk.sv
module trap_peak_trigger_chk #(
    parameter int W = 26
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                valid_i,
    input logic signed [W-1:0] thresh_i,
    input logic                event_o,
    input logic signed [W-1:0] peak_o,
    input logic signed [W-1:0] filt_i
);

    // R7: the event pulse lasts a single cycle
    a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        event_o |=> !event_o);

    // R3: a reported peak lies strictly above the threshold in force
    a_r3_above_thresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
        event_o |-> (peak_o > $past(thresh_i)));

    // R5: the peak output moves only together with an event
    a_r5_peak_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(peak_o) |-> event_o);

    // R8: a stalled input cycle leaves the shaped value unchanged downstream
    a_r8_stall_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> ##1 $stable(filt_i));

    // R1: outputs quiet during reset
    a_r1_reset_quiet: assert property (@(posedge clk_i)
        !rst_ni |=> (!event_o && peak_o == '0));

endmodule

bind trap_peak_trigger trap_peak_trigger_chk #(.W($bits(peak_o))) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .thresh_i (thresh_i),
    .event_o  (event_o),
    .peak_o   (peak_o),
    .filt_i   (filt_data)
);

// File: tb/trap_peak_trigger_bench.sv
`timescale 1ns/1ps
module trap_peak_trigger_bench;

    localparam int DW = 14;
    localparam int SW = 26;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 valid = 1'b0;
    logic signed [DW-1:0] sample = '0;
    logic signed [SW-1:0] thresh = '0;
    logic                 event_w;
    logic signed [SW-1:0] peak_w;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    trap_peak_trigger u_trap_peak_trigger (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .valid_i  (valid),
        .sample_i (sample),
        .thresh_i (thresh),
        .event_o  (event_w),
        .peak_o   (peak_w)
    );

    // amp, width, threshold, events expected, event edge, peak
    typedef struct packed {
        logic signed [15:0] amp;
        logic [7:0]         width;
        logic signed [31:0] thr;
        logic [1:0]         fires;
        logic [7:0]         edge_no;
        logic signed [31:0] peak;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{16'sd100,   8'd1,  32'sd200,  2'd1, 8'd6,  32'sd400},    // R4 impulse
        '{16'sd100,   8'd1,  32'sd400,  2'd0, 8'd0,  32'sd400},    // R3 equal: no fire
        '{16'sd100,   8'd1,  32'sd399,  2'd1, 8'd6,  32'sd400},    // R3 one below
        '{16'sd5,     8'd3,  32'sd10,   2'd1, 8'd8,  32'sd60},     // R2 width 3
        '{-16'sd300,  8'd2,  32'sd10,   2'd0, 8'd0,  32'sd60},     // R3 negative
        '{16'sd50,    8'd20, 32'sd100,  2'd1, 8'd13, 32'sd1600},   // R6 long plateau
        '{16'sd8191,  8'd20, 32'sd1000, 2'd1, 8'd13, 32'sd262112}, // R2 full scale
        '{-16'sd8192, 8'd20, 32'sd1000, 2'd0, 8'd0,  32'sd262112}, // R2 neg full scale
        '{16'sd2,     8'd5,  32'sd0,    2'd1, 8'd10, 32'sd40}      // R4 width 5
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drives a rectangular pulse (plus optional extra impulse) then zeros.
    task automatic run_seq(input int amp, input int width, input int extra_at,
                           input longint thr, input bit gaps, input int ncyc,
                           output int cnt, output int e1, output int e2,
                           output int highs);
        int idx;
        thresh = SW'(thr);
        cnt = 0; e1 = -1; e2 = -1; highs = 0; idx = 0;
        for (int cyc = 0; cyc < ncyc; cyc++) begin
            @(negedge clk);
            if (event_w) begin
                highs++;
                if (cnt == 0) e1 = cyc - 1;
                else if (cnt == 1) e2 = cyc - 1;
                cnt++;
            end
            valid = gaps ? (cyc % 2 == 0) : 1'b1;
            if (valid) begin
                sample = DW'(((idx < width) ? amp : 0) + ((idx == extra_at) ? amp : 0));
                idx++;
            end else begin
                sample = 14'sd8000;
            end
        end
        @(negedge clk);
        valid  = 1'b1;
        sample = '0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cnt, e1, e2, highs;
        longint last_peak;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(event_w == 1'b0, "R1 event in reset", event_w, 0);
        check(peak_w == '0, "R1 peak in reset", peak_w, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(event_w == 1'b0 && peak_w == '0, "R1 after reset", peak_w, 0);

        last_peak = 0;
        for (int v = 0; v < NVEC; v++) begin
            run_seq(int'(VECS[v].amp), int'(VECS[v].width), -1, longint'(VECS[v].thr),
                    1'b0, 48, cnt, e1, e2, highs);
            check(cnt == int'(VECS[v].fires), "R3 event count", cnt, VECS[v].fires);
            check(highs == cnt, "R7 pulse width", highs, cnt);
            if (VECS[v].fires != 0) begin
                check(e1 == int'(VECS[v].edge_no), "R4 event edge", e1, VECS[v].edge_no);
                check(peak_w == SW'(VECS[v].peak), "R2 peak value", peak_w, VECS[v].peak);
                last_peak = longint'(VECS[v].peak);
            end else begin
                check(peak_w == SW'(last_peak), "R5 peak held", peak_w, last_peak);
            end
        end

        // R6: overlapping impulses never drop below threshold -> one event
        run_seq(100, 1, 2, 50, 1'b0, 48, cnt, e1, e2, highs);
        check(cnt == 1, "R6 overlap count", cnt, 1);
        check(e1 == 8, "R4 overlap edge", e1, 8);
        check(peak_w == 26'sd800, "R5 overlap peak", peak_w, 800);

        // R6: separated impulses re-arm -> two events
        run_seq(100, 1, 20, 200, 1'b0, 60, cnt, e1, e2, highs);
        check(cnt == 2, "R6 rearm count", cnt, 2);
        check(e1 == 6, "R6 first edge", e1, 6);
        check(e2 == 26, "R6 second edge", e2, 26);

        // R8: stalled cycles carry junk that must be ignored
        run_seq(100, 1, -1, 200, 1'b1, 100, cnt, e1, e2, highs);
        check(cnt == 1, "R8 gapped count", cnt, 1);
        check(peak_w == 26'sd400, "R8 gapped peak", peak_w, 400);

        // R1: reset in mid-operation clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(peak_w == '0 && event_w == 1'b0, "R1 re-reset", peak_w, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule